// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit host reach a small byte-addressed back-end register space through a short command and data exchange, so the back-end never appears in the host's address map. The host writes a command word into the command register: a direction bit, a size bit, two groups of byte-lane enables and an 8-bit back-end address. A read command starts the back-end access at once, and the fetched bytes appear in the data registers once the busy bit drops. A write command only arms the bridge. The access itself starts when the host next writes the lower data register. A fixed back-end latency of `LAT` cycles keeps the busy bit high. While busy is high the command and data registers cannot be changed.

The bridge also collects two interrupt sources into a flag register that is cleared by writing 1, with a matching enable register. Source 0 is the bridge itself: it fires when an access completes. Source 1 is the back-end request line, which is captured on its rising edge. The back-end register contents are held in a behavioural byte memory.

The host side uses valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Each accepted read produces exactly one response. `rsp_valid` and `rsp_rdata` stay unchanged until `rsp_ready` is high. `req_ready` is low while a response is waiting, so the host can stall the bridge by holding `rsp_ready` low. Writes produce no response.

Top module: `ibr_bridge`

## Requirements
- R1: Offset 0x00 reads the constant `ID_VALUE`. Offsets not in {0x00, 0x04, 0x08, 0x0C, 0x10, 0x14} read as 0, and writes to them have no effect.
- R2: The command register at 0x04 reads back its fields as follows:
  - bit 31: busy (read-only)
  - bit 25: size
  - bit 24: direction (1 = read)
  - bits 23:20: upper lane enables
  - bits 19:16: lower lane enables
  - bits 7:0: back-end address
  
  All other bits read 0, and writing bit 31 has no effect.
- R3: A command write with direction 0 arms a write. The next write to the lower data register (0x08) starts it. Busy reads 1 from the cycle after that data write, for `LAT` cycles. Lower lane k stores byte k of the lower data into back-end address (addr+k) mod 256.
- R4: When a write has size 1, upper lane k also stores byte k of the upper data register (0x0C) into address (addr+4+k) mod 256.
- R5: A command write with direction 1 starts a read at once, with busy held for `LAT` cycles. When the read ends, the lower data register takes byte k from (addr+k) for each enabled lower lane and 0 for each disabled lane. With size 1, the upper data register is loaded the same way from (addr+4+k). With size 0, the upper data register is left unchanged.
- R6: Writes to the command register or to either data register while busy is 1 are ignored. This includes a write on the last busy cycle.
- R7: A lower-data write with no armed write command only stores the data. It starts no access and leaves busy at 0.
- R8: Flag bit 0 (0x14) sets when any back-end access completes. Flag bit 1 sets on a rising edge of `be_req`. Writing 1 clears a flag bit. A set on the same cycle as a clear wins.
- R9: `irq` is 1 exactly when some flag bit and the same bit of the enable register (0x10, bits 1:0) are both 1.
- R10: A request is taken when `req_valid` and `req_ready` are both 1. Each read gets one response, valid from the next cycle. The response stays unchanged while `rsp_ready` is 0, and `req_ready` is 0 while a response is pending.
- R11: After reset, the command, data, enable and flag registers are 0, busy is 0, `irq` is 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Host register byte offset |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| be_req | input | 1 | Back-end interrupt request line |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Writes and reads are exercised in several forms:
- a single lane;
- all four lower lanes;
- all eight lanes with size 1;
- sparse lane masks, which separate correct per-lane masking from whole-word transfers;
- a range that wraps past address 0xFF, which exposes address carry errors.

Writes are also issued during busy, including on the last busy cycle, and a data write is issued with no armed command. These show whether the busy gate and the arming rule hold.

Interrupt sequences cover completion flags, a `be_req` that stays high across a clear, and masking with each enable bit. They separate level capture from edge capture and W1C from plain writes.

Reads are issued back to back while `rsp_ready` is pulsed low, to show that responses are neither lost nor reordered under back-pressure.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_AW = 5;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int BE_AW   = 8;
  localparam int NSRC    = 2;

  localparam logic [HOST_AW-1:0] OFS_ID   = 5'h00;
  localparam logic [HOST_AW-1:0] OFS_CTL  = 5'h04;
  localparam logic [HOST_AW-1:0] OFS_LDAT = 5'h08;
  localparam logic [HOST_AW-1:0] OFS_UDAT = 5'h0C;
  localparam logic [HOST_AW-1:0] OFS_IEN  = 5'h10;
  localparam logic [HOST_AW-1:0] OFS_IFLG = 5'h14;

  localparam int B_BUSY = 31;
  localparam int B_SIZE = 25;
  localparam int B_DIR  = 24;
  localparam int B_UBE  = 20;
  localparam int B_LBE  = 16;

  localparam int SRC_IF = 0;
  localparam int SRC_SS = 1;

  typedef struct packed {
    logic             size;
    logic             dir;
    logic [LANES-1:0] ube;
    logic [LANES-1:0] lbe;
    logic [BE_AW-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_wr,
  input  logic               start_rd,
  input  logic               size,
  input  logic [LANES-1:0]   ube,
  input  logic [LANES-1:0]   lbe,
  output logic               busy,
  output logic               done_any,
  output logic               done_rd,
  output logic [2*LANES-1:0] lanes,
  output logic [2*LANES-1:0] wen
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt;
  logic          is_rd;

  assign done_any = busy && (cnt == '0);
  assign done_rd  = done_any && is_rd;
  assign lanes    = {size ? ube : {LANES{1'b0}}, lbe};
  assign wen      = (done_any && !is_rd) ? lanes : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      is_rd <= 1'b0;
    end else if ((start_wr || start_rd) && !busy) begin
      busy  <= 1'b1;
      cnt   <= CW'(LAT - 1);
      is_rd <= start_rd;
    end else if (done_any) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr || start_rd) |=> busy);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/ibr_bemem.sv
module ibr_bemem #(
  parameter int AW = 8,
  parameter int NB = 8
) (
  input  logic            clk,
  input  logic [AW-1:0]   base,
  input  logic [NB-1:0]   wen,
  input  logic [NB*8-1:0] wdata,
  output logic [NB*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [AW-1:0] ra;
    assign ra = base + AW'(k);
    assign rdata[k*8 +: 8] = mem[ra];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NB; k++) begin
      if (wen[k]) mem[base + AW'(k)] <= wdata[k*8 +: 8];
    end
  end
endmodule

// File: rtl/ibr_irq.sv
module ibr_irq
  import ibr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            be_req,
  input  logic            done,
  input  logic [NSRC-1:0] w1c,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic            be_q;
  logic [NSRC-1:0] set;

  always_comb begin
    set         = '0;
    set[SRC_IF] = done;
    set[SRC_SS] = be_req && !be_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_q  <= 1'b0;
      flags <= '0;
    end else begin
      be_q  <= be_req;
      flags <= (flags & ~w1c) | set;
    end
  end

  assign irq = |(flags & en);

  // R8
  ss_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) |=> flags[SRC_SS]);

  // R8
  if_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[SRC_IF] && !done) |=> !flags[SRC_IF]);
endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
  import ibr_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h4942_5201
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [HOST_AW-1:0]   req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_rdata,
  input  logic                 busy,
  input  logic                 rd_done,
  input  logic [2*LANES-1:0]   lanes,
  input  logic [2*WORD_W-1:0]  rd_bytes,
  input  logic [NSRC-1:0]      flags,
  output cmd_t                 cmd,
  output logic [WORD_W-1:0]    ldata,
  output logic [WORD_W-1:0]    udata,
  output logic                 start_wr,
  output logic                 start_rd,
  output logic [NSRC-1:0]      ien,
  output logic [NSRC-1:0]      flag_w1c
);
  logic                acc, wr, rd;
  logic                ctl_we, ld_we, ud_we;
  logic                armed;
  logic [2*WORD_W-1:0] masked;
  logic [WORD_W-1:0]   ctl_view, rmux;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign ctl_we    = wr && (req_addr == OFS_CTL)  && !busy;
  assign ld_we     = wr && (req_addr == OFS_LDAT) && !busy;
  assign ud_we     = wr && (req_addr == OFS_UDAT) && !busy;
  assign start_rd  = ctl_we && req_wdata[B_DIR];
  assign start_wr  = ld_we && armed;
  assign flag_w1c  = (wr && (req_addr == OFS_IFLG)) ? req_wdata[NSRC-1:0] : '0;

  always_comb begin
    for (int k = 0; k < 2*LANES; k++) begin
      masked[k*8 +: 8] = lanes[k] ? rd_bytes[k*8 +: 8] : 8'h00;
    end
  end

  assign ctl_view = {busy, 5'b0, cmd.size, cmd.dir, cmd.ube, cmd.lbe,
                     {(16-BE_AW){1'b0}}, cmd.addr};

  always_comb begin
    case (req_addr)
      OFS_ID:   rmux = ID_VALUE;
      OFS_CTL:  rmux = ctl_view;
      OFS_LDAT: rmux = ldata;
      OFS_UDAT: rmux = udata;
      OFS_IEN:  rmux = {{(WORD_W-NSRC){1'b0}}, ien};
      OFS_IFLG: rmux = {{(WORD_W-NSRC){1'b0}}, flags};
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd       <= '0;
      armed     <= 1'b0;
      ldata     <= '0;
      udata     <= '0;
      ien       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (ctl_we) begin
        cmd.size <= req_wdata[B_SIZE];
        cmd.dir  <= req_wdata[B_DIR];
        cmd.ube  <= req_wdata[B_UBE +: LANES];
        cmd.lbe  <= req_wdata[B_LBE +: LANES];
        cmd.addr <= req_wdata[BE_AW-1:0];
        armed    <= !req_wdata[B_DIR];
      end
      if (ld_we) begin
        ldata <= req_wdata;
        armed <= 1'b0;
      end
      if (ud_we) udata <= req_wdata;
      if (rd_done) begin
        ldata <= masked[WORD_W-1:0];
        if (cmd.size) udata <= masked[2*WORD_W-1:WORD_W];
      end
      if (wr && (req_addr == OFS_IEN)) ien <= req_wdata[NSRC-1:0];
      if (rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rmux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd));

  // R7
  no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && !armed) |=> !busy);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int          LAT      = 4,
  parameter logic [31:0] ID_VALUE = 32'h4942_5201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  input  logic        be_req,
  output logic        irq
);
  cmd_t                cmd;
  logic [WORD_W-1:0]   ldata, udata;
  logic                start_wr, start_rd;
  logic                busy, done_any, done_rd;
  logic [2*LANES-1:0]  lanes, wen;
  logic [2*WORD_W-1:0] rd_bytes;
  logic [NSRC-1:0]     ien, flags, flag_w1c;

  ibr_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .busy(busy), .rd_done(done_rd), .lanes(lanes), .rd_bytes(rd_bytes),
    .flags(flags), .cmd(cmd), .ldata(ldata), .udata(udata),
    .start_wr(start_wr), .start_rd(start_rd), .ien(ien), .flag_w1c(flag_w1c)
  );

  ibr_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .size(cmd.size), .ube(cmd.ube), .lbe(cmd.lbe),
    .busy(busy), .done_any(done_any), .done_rd(done_rd),
    .lanes(lanes), .wen(wen)
  );

  ibr_bemem #(.AW(BE_AW), .NB(2*LANES)) u_mem (
    .clk(clk), .base(cmd.addr), .wen(wen),
    .wdata({udata, ldata}), .rdata(rd_bytes)
  );

  ibr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .be_req(be_req), .done(done_any),
    .w1c(flag_w1c), .en(ien), .flags(flags), .irq(irq)
  );
endmodule

// File: tb/sim_ibr_bridge.sv
`timescale 1ns/1ps
module sim_ibr_bridge;
  localparam int          LAT = 4;
  localparam logic [31:0] IDV = 32'h4942_5201;
  localparam logic [4:0]  A_ID = 5'h00, A_CTL = 5'h04, A_LD = 5'h08,
                          A_UD = 5'h0C, A_EN = 5'h10, A_FL = 5'h14;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1, be_req = 0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  mdl [256];
  logic [31:0] m_ud = '0;
  bit          bp_on = 0;

  always #2.5 clk = ~clk;

  ibr_bridge #(.LAT(LAT), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .be_req(be_req), .irq(irq)
  );

  initial forever begin
    @(posedge clk);
    cyc++;
    #1 rsp_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data in order
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", rsp_rdata, 32'hxxxxxxxx);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] cw(bit sz, bit dir, logic [3:0] ube,
                                     logic [3:0] lbe, logic [7:0] a);
    return {1'b0, 5'b0, sz, dir, ube, lbe, 8'h00, a};
  endfunction

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic bus_rd(logic [4:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic acc_wr(logic [7:0] a, bit sz, logic [3:0] ube, logic [3:0] lbe,
                        logic [31:0] ud, logic [31:0] ld, bit busy_chk, string tag);
    drain();
    if (sz) begin bus_wr(A_UD, ud); m_ud = ud; end
    bus_wr(A_CTL, cw(sz, 0, ube, lbe, a));
    bus_wr(A_LD, ld);
    if (busy_chk) bus_rd(A_CTL, cw(sz, 0, ube, lbe, a) | 32'h8000_0000, tag);
    settle();
    for (int k = 0; k < 4; k++) begin
      if (lbe[k]) mdl[8'(a + 8'(k))] = ld[k*8 +: 8];
      if (sz && ube[k]) mdl[8'(a + 8'(4 + k))] = ud[k*8 +: 8];
    end
  endtask

  task automatic acc_rd(logic [7:0] a, bit sz, logic [3:0] ube, logic [3:0] lbe, string tag);
    logic [31:0] el, eu;
    drain();
    bus_wr(A_CTL, cw(sz, 1, ube, lbe, a));
    settle();
    for (int k = 0; k < 4; k++) begin
      el[k*8 +: 8] = lbe[k] ? mdl[8'(a + 8'(k))] : 8'h00;
      eu[k*8 +: 8] = ube[k] ? mdl[8'(a + 8'(4 + k))] : 8'h00;
    end
    bus_rd(A_LD, el, tag);
    if (sz) m_ud = eu;
    bus_rd(A_UD, m_ud, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 0);
    chk("R11 req_ready", {31'b0, req_ready}, 1);
    bus_rd(A_CTL, 0, "R11 ctl");
    bus_rd(A_FL, 0, "R11 flag");
    bus_rd(A_LD, 0, "R11 ldata");
    bus_rd(A_EN, 0, "R11 en");
    // R1 id and unmapped
    bus_rd(A_ID, IDV, "R1 id");
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_rd(5'h18, 0, "R1 unmapped");
    bus_rd(5'h06, 0, "R1 unaligned");
    // R2 field layout, bit 31 not writable
    bus_wr(A_CTL, 32'hFEFF_FF5A);
    bus_rd(A_CTL, 32'h02FF_005A, "R2 ctl view");

    // R3 single lane write with busy visible, R5 readback
    acc_wr(8'h10, 0, 4'h0, 4'h1, 0, 32'h0000_00A5, 1, "R3 busy");
    acc_rd(8'h10, 0, 4'h0, 4'h1, "R5 single");
    // R3 four lanes, R5 sparse mask
    acc_wr(8'h20, 0, 4'h0, 4'hF, 0, 32'h4433_2211, 0, "R3");
    acc_rd(8'h20, 0, 4'h0, 4'h5, "R5 sparse mask");
    acc_rd(8'h20, 0, 4'h0, 4'hF, "R3 four lanes");
    // R4 size 1, eight lanes
    acc_wr(8'h40, 1, 4'hF, 4'hF, 32'h8877_6655, 32'h4433_2211, 0, "R4");
    acc_rd(8'h40, 1, 4'hF, 4'hF, "R4 eight lanes");
    acc_rd(8'h40, 1, 4'hA, 4'h0, "R5 upper mask");
    acc_rd(8'h40, 0, 4'hF, 4'h3, "R5 size0 upper kept");
    // R3 address wrap
    acc_wr(8'hFE, 0, 4'h0, 4'hF, 0, 32'hDDCC_BBAA, 0, "R3");
    acc_rd(8'h00, 0, 4'h0, 4'h3, "R3 wrap");
    acc_rd(8'hFE, 0, 4'h0, 4'hF, "R3 wrap full");

    // R6 writes during busy ignored (last one on final busy cycle)
    drain();
    bus_wr(A_CTL, cw(0, 0, 4'h0, 4'hF, 8'h60));
    bus_wr(A_LD, 32'h0BAD_F00D);
    bus_wr(A_CTL, cw(0, 1, 4'h0, 4'hF, 8'h70));
    bus_wr(A_LD, 32'h1111_1111);
    settle();
    for (int k = 0; k < 4; k++) mdl[8'(8'h60 + 8'(k))] = 8'(32'h0BAD_F00D >> (8*k));
    bus_rd(A_CTL, cw(0, 0, 4'h0, 4'hF, 8'h60), "R6 ctl kept");
    bus_rd(A_LD, 32'h0BAD_F00D, "R6 data kept");
    acc_rd(8'h60, 0, 4'h0, 4'hF, "R6 mem");

    // R7 data write without armed command
    drain();
    bus_wr(A_LD, 32'h5A5A_5A5A);
    bus_rd(A_CTL, cw(0, 1, 4'h0, 4'hF, 8'h60), "R7 no busy");
    bus_rd(A_LD, 32'h5A5A_5A5A, "R7 data stored");
    acc_rd(8'h60, 0, 4'h0, 4'hF, "R7 mem unchanged");

    // R8 / R9 interrupts
    drain();
    bus_wr(A_FL, 32'h3);
    bus_rd(A_FL, 0, "R8 w1c both");
    acc_wr(8'h80, 0, 4'h0, 4'h1, 0, 32'h77, 0, "R8");
    bus_rd(A_FL, 32'h1, "R8 done flag");
    drain();
    chk("R9 masked", {31'b0, irq}, 0);
    bus_wr(A_EN, 32'h1);
    chk("R9 enabled", {31'b0, irq}, 1);
    bus_wr(A_FL, 32'h1);
    chk("R9 cleared", {31'b0, irq}, 0);
    bus_rd(A_FL, 0, "R8 w1c");
    drain();
    be_req = 1;
    @(negedge clk);
    bus_rd(A_FL, 32'h2, "R8 edge");
    drain();
    chk("R9 en bit1 off", {31'b0, irq}, 0);
    bus_wr(A_EN, 32'h3);
    chk("R9 en bit1 on", {31'b0, irq}, 1);
    bus_wr(A_FL, 32'h2);
    repeat (3) @(negedge clk);
    bus_rd(A_FL, 0, "R8 level not re-set");
    drain();
    chk("R9 after clear", {31'b0, irq}, 0);
    be_req = 0;
    @(negedge clk);
    be_req = 1;
    @(negedge clk);
    bus_rd(A_FL, 32'h2, "R8 second edge");

    // R10 back-pressure, back-to-back reads in order
    drain();
    bp_on = 1;
    for (int i = 0; i < 6; i++) begin
      bus_rd(A_ID, IDV, "R10 bp id");
      bus_rd(A_EN, 32'h3, "R10 bp en");
      bus_rd(A_LD, 32'h0000_0077, "R10 bp ld");
    end
    drain();
    bp_on = 0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule